// File: doc/BRIEF.md
# Bus width address adapter

This block connects a 32-bit bus master to a slave whose data path is 8, 16 or 32 bits wide. The master side carries a byte address, four byte enables, read and write strobes, 32-bit write and read data, and a wait signal. The slave side carries a word address at the slave's own width, byte enables for the slave's lanes, strobes, write and read data, and a wait input.

A parameter chooses between two mappings. In the packed mapping, every master byte reaches a slave byte in little-endian order. A 32-bit master access to a narrow slave becomes a short series of slave accesses, starting at the lowest address. Only the slave words that have at least one enabled byte are visited. In the sparse mapping, each slave word sits at the start of one 32-bit master word. Only the low master lanes that fit the slave are carried. The upper lanes are dropped on writes and read back as zero.

The master holds its request until the wait signal drops. The read data is fully assembled in the same cycle that the wait signal drops.

Top module: `bwa_adapter`

## Requirements
- R1: While reset is high and in the first cycle after it, neither slave strobe is asserted, and the wait output stays low while the master requests nothing.
- R2: In packed mode with a 16-bit slave, the master word at byte address A (a multiple of 4) holds slave words A/2 and A/2+1. Master lanes 1:0 map to the lower slave word, with lane 0 (bits 7:0) at the lower byte address.
- R3: In packed mode, the slave words of one master access are issued in rising address order. A slave word whose master byte enables are all low is skipped. Every issued slave cycle has a nonzero byte enable, and read and write are never asserted together.
- R4: The slave byte enable bit j equals master enable bit (k*L + j) for slave word k of the master word, where L is the slave width in bytes. Master enable bit i qualifies master data bits 8i+7:8i. Write data is carried on the same lanes.
- R5: Read data from each issued slave word is placed in the master lanes it maps to. Lanes of skipped slave words read as zero.
- R6: The wait output is high from the request until every slave cycle has finished. It drops N*(W+1)+1 rising edges after the request is first sampled, where N is the number of issued slave cycles and W is the slave's wait cycles per cycle. While the slave waits, the slave address, byte enables and strobe hold steady.
- R7: A master access with all four byte enables low issues no slave cycle. It completes after one edge, and a read returns zero.
- R8: In sparse mode with a 16-bit slave, master byte address 4n reaches slave word n in a single slave cycle. Only master lanes 1:0 are carried, and lanes 3:2 read as zero. If enables 1:0 are both low, no slave cycle is issued.
- R9: In packed mode with an 8-bit slave, the slave address equals the master byte address. A full-word access becomes four byte cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | ADDR_W | Master byte address |
| m_be | input | 4 | Master byte enables, bit i for lane i |
| m_rd | input | 1 | Master read request |
| m_wr | input | 1 | Master write request |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Assembled read data, valid when m_wait is low |
| m_wait | output | 1 | Hold request while high |
| s_addr | output | SA_W | Slave word address |
| s_be | output | SLV_W/8 | Slave byte enables |
| s_rd | output | 1 | Slave read strobe |
| s_wr | output | 1 | Slave write strobe |
| s_wdata | output | SLV_W | Slave write data |
| s_rdata | input | SLV_W | Slave read data |
| s_wait | input | 1 | Slave stall |

## Verification
A wrong pending-word mask or slice index in the sequencer appears on the very next slave strobe cycle. It shows as a wrong slave address, an extra or missing slave cycle, or a zero byte enable, and the access counts and address logs catch it within that transfer. A lane placement fault in read assembly stays hidden until the wait output drops, then shows as a misplaced byte in the returned word. A sequencer that never reaches completion holds the wait output high, so the edge counts taken per transfer expose a stuck or early release at once.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    localparam int MST_W     = 32;
    localparam int MST_LANES = MST_W / 8;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_DONE = 2'd2
    } sq_state_e;

    typedef struct packed {
        sq_state_e  st;
        logic       is_wr;
        logic [1:0] idx;
        logic [3:0] pend;
    } sq_reg_t;

    function automatic int slice_count(int slv_w, bit native);
        return native ? 1 : MST_W / slv_w;
    endfunction

    function automatic int slv_addr_w(int addr_w, int slv_w, bit native);
        return native ? addr_w - 2 : addr_w - $clog2(slv_w / 8);
    endfunction

    // lowest set bit of a slice mask
    function automatic logic [1:0] first_set(logic [3:0] m);
        logic [1:0] r;
        r = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (m[i]) r = 2'(i);
        end
        return r;
    endfunction

    // one bit per slave word that has an enabled master lane
    function automatic logic [3:0] enabled_slices(logic [3:0] be, int lanes, int nsl);
        logic [3:0] r;
        r = '0;
        for (int b = 0; b < MST_LANES; b++) begin
            if (b < lanes * nsl && be[b]) r[b / lanes] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/bwa_lane_map.sv
module bwa_lane_map
    import bwa_pkg::*;
#(
    parameter int SLV_W  = 16,
    parameter bit NATIVE = 1'b0,
    parameter int ADDR_W = 16,
    parameter int SA_W   = slv_addr_w(ADDR_W, SLV_W, NATIVE)
) (
    input  logic [ADDR_W-1:0]  m_addr,
    input  logic [3:0]         m_be,
    input  logic [MST_W-1:0]   m_wdata,
    input  logic [1:0]         idx,
    input  logic [SLV_W-1:0]   s_rdata,
    input  logic [MST_W-1:0]   rbuf,
    output logic [SA_W-1:0]    s_addr,
    output logic [SLV_W/8-1:0] s_be,
    output logic [SLV_W-1:0]   s_wdata,
    output logic [3:0]         slices,
    output logic [MST_W-1:0]   merged
);
    localparam int LANES = SLV_W / 8;
    localparam int NSL   = slice_count(SLV_W, NATIVE);
    localparam int IDXW  = (NATIVE || SLV_W == MST_W) ? 0 : 2 - $clog2(LANES);

    logic unused_bits;
    assign unused_bits = ^{m_addr[1:0], idx};

    generate
        if (IDXW == 0) begin : g_word_addr
            assign s_addr = m_addr[ADDR_W-1:2];
        end else begin : g_sub_addr
            assign s_addr = {m_addr[ADDR_W-1:2], idx[IDXW-1:0]};
        end
    endgenerate

    assign s_be    = LANES'(m_be >> (32'(idx) * LANES));
    assign s_wdata = SLV_W'(m_wdata >> (32'(idx) * SLV_W));
    assign slices  = enabled_slices(m_be, LANES, NSL);
    assign merged  = rbuf | (MST_W'(s_rdata) << (32'(idx) * SLV_W));

endmodule

// File: rtl/bwa_seq.sv
module bwa_seq
    import bwa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_wr,
    input  logic [3:0]       slices,
    input  logic             s_wait,
    input  logic [MST_W-1:0] merged,
    output sq_reg_t          q,
    output logic [MST_W-1:0] rbuf
);
    logic [3:0] rest;
    assign rest = q.pend & ~(4'b0001 << q.idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st    <= SQ_IDLE;
            q.is_wr <= 1'b0;
            q.idx   <= 2'd0;
            q.pend  <= 4'd0;
            rbuf    <= '0;
        end else begin
            case (q.st)
                SQ_IDLE: begin
                    if (req) begin
                        rbuf    <= '0;
                        q.is_wr <= req_wr;
                        q.pend  <= slices;
                        if (slices == 4'd0) begin
                            q.st <= SQ_DONE;
                        end else begin
                            q.idx <= first_set(slices);
                            q.st  <= SQ_RUN;
                        end
                    end
                end
                SQ_RUN: begin
                    if (!s_wait) begin
                        if (!q.is_wr) rbuf <= merged;
                        q.pend <= rest;
                        if (rest == 4'd0) q.st <= SQ_DONE;
                        else              q.idx <= first_set(rest);
                    end
                end
                SQ_DONE: q.st <= SQ_IDLE;
                default: q.st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bwa_adapter.sv
module bwa_adapter
    import bwa_pkg::*;
#(
    parameter int SLV_W  = 16,
    parameter bit NATIVE = 1'b0,
    parameter int ADDR_W = 16,
    localparam int SA_W  = slv_addr_w(ADDR_W, SLV_W, NATIVE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  m_addr,
    input  logic [3:0]         m_be,
    input  logic               m_rd,
    input  logic               m_wr,
    input  logic [31:0]        m_wdata,
    output logic [31:0]        m_rdata,
    output logic               m_wait,
    output logic [SA_W-1:0]    s_addr,
    output logic [SLV_W/8-1:0] s_be,
    output logic               s_rd,
    output logic               s_wr,
    output logic [SLV_W-1:0]   s_wdata,
    input  logic [SLV_W-1:0]   s_rdata,
    input  logic               s_wait
);
    sq_reg_t          q;
    logic [3:0]       slices;
    logic [MST_W-1:0] rbuf;
    logic [MST_W-1:0] merged;
    logic             req;

    assign req = m_rd | m_wr;

    bwa_lane_map #(
        .SLV_W (SLV_W),
        .NATIVE(NATIVE),
        .ADDR_W(ADDR_W),
        .SA_W  (SA_W)
    ) u_map (
        .m_addr (m_addr),
        .m_be   (m_be),
        .m_wdata(m_wdata),
        .idx    (q.idx),
        .s_rdata(s_rdata),
        .rbuf   (rbuf),
        .s_addr (s_addr),
        .s_be   (s_be),
        .s_wdata(s_wdata),
        .slices (slices),
        .merged (merged)
    );

    bwa_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .req_wr(m_wr),
        .slices(slices),
        .s_wait(s_wait),
        .merged(merged),
        .q     (q),
        .rbuf  (rbuf)
    );

    assign s_rd    = (q.st == SQ_RUN) & ~q.is_wr;
    assign s_wr    = (q.st == SQ_RUN) &  q.is_wr;
    assign m_wait  = req & (q.st != SQ_DONE);
    assign m_rdata = rbuf;

endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
    parameter int SA_W  = 15,
    parameter int LANES = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            m_wait,
    input logic [SA_W-1:0] s_addr,
    input logic [LANES-1:0] s_be,
    input logic            s_rd,
    input logic            s_wr,
    input logic            s_wait
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> !(s_rd || s_wr));

    a_r3_nonzero_be: assert property (@(posedge clk) disable iff (rst)
        (s_rd || s_wr) |-> (s_be != '0));

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(s_rd && s_wr));

    a_r6_hold_master: assert property (@(posedge clk) disable iff (rst)
        (s_rd || s_wr) |-> m_wait);

    a_r6_stable_slave: assert property (@(posedge clk) disable iff (rst)
        ((s_rd || s_wr) && s_wait) |=>
            ((s_rd || s_wr) && $stable(s_addr) && $stable(s_be)));

endmodule

bind bwa_adapter bwa_checker #(
    .SA_W (SA_W),
    .LANES(SLV_W / 8)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .m_wait(m_wait),
    .s_addr(s_addr),
    .s_be  (s_be),
    .s_rd  (s_rd),
    .s_wr  (s_wr),
    .s_wait(s_wait)
);

// File: tb/bwa_adapter_tb.sv
`timescale 1ns/1ps

module bwa_slave_model #(
    parameter int W  = 16,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] s_addr,
    input  logic [W/8-1:0] s_be,
    input  logic          s_rd,
    input  logic          s_wr,
    input  logic [W-1:0]  s_wdata,
    output logic [W-1:0]  s_rdata,
    output logic          s_wait,
    input  int            wait_cyc
);
    localparam int DEPTH = 1 << AW;
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] log_a [16];
    int            acc_cnt;
    int            cnt;

    assign s_wait  = (s_rd || s_wr) && (cnt < wait_cyc);
    assign s_rdata = mem[s_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= 0;
            acc_cnt <= 0;
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (s_rd || s_wr) begin
            if (cnt < wait_cyc) begin
                cnt <= cnt + 1;
            end else begin
                cnt <= 0;
                if (s_wr) begin
                    for (int b = 0; b < W/8; b++)
                        if (s_be[b]) mem[s_addr][8*b +: 8] <= s_wdata[8*b +: 8];
                end
                log_a[4'(acc_cnt)] <= s_addr;
                acc_cnt <= acc_cnt + 1;
            end
        end
    end
endmodule

module bwa_adapter_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [7:0]  m_addr  = '0;
    logic [3:0]  m_be    = '0;
    logic [31:0] m_wdata = '0;
    int wc_d = 0, wc_n = 0, wc_b = 0;
    int n_chk = 0, n_fail = 0;

    // packed mode, 16-bit slave
    logic d_rd = 0, d_wr = 0, d_wait, d_srd, d_swr, d_swait;
    logic [31:0] d_rdata;
    logic [6:0]  d_saddr;
    logic [1:0]  d_sbe;
    logic [15:0] d_swdata, d_srdata;
    // sparse mode, 16-bit slave
    logic n_rd = 0, n_wr = 0, n_wait, n_srd, n_swr, n_swait;
    logic [31:0] n_rdata;
    logic [5:0]  n_saddr;
    logic [1:0]  n_sbe;
    logic [15:0] n_swdata, n_srdata;
    // packed mode, 8-bit slave
    logic b_rd = 0, b_wr = 0, b_wait, b_srd, b_swr, b_swait;
    logic [31:0] b_rdata;
    logic [7:0]  b_saddr;
    logic [0:0]  b_sbe;
    logic [7:0]  b_swdata, b_srdata;

    bwa_adapter #(.SLV_W(16), .NATIVE(1'b0), .ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_be(m_be), .m_rd(d_rd), .m_wr(d_wr),
        .m_wdata(m_wdata), .m_rdata(d_rdata), .m_wait(d_wait), .s_addr(d_saddr),
        .s_be(d_sbe), .s_rd(d_srd), .s_wr(d_swr), .s_wdata(d_swdata),
        .s_rdata(d_srdata), .s_wait(d_swait));
    bwa_slave_model #(.W(16), .AW(7)) u_sm_d (
        .clk(clk), .rst(rst), .s_addr(d_saddr), .s_be(d_sbe), .s_rd(d_srd), .s_wr(d_swr),
        .s_wdata(d_swdata), .s_rdata(d_srdata), .s_wait(d_swait), .wait_cyc(wc_d));

    bwa_adapter #(.SLV_W(16), .NATIVE(1'b1), .ADDR_W(8)) u_nat (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_be(m_be), .m_rd(n_rd), .m_wr(n_wr),
        .m_wdata(m_wdata), .m_rdata(n_rdata), .m_wait(n_wait), .s_addr(n_saddr),
        .s_be(n_sbe), .s_rd(n_srd), .s_wr(n_swr), .s_wdata(n_swdata),
        .s_rdata(n_srdata), .s_wait(n_swait));
    bwa_slave_model #(.W(16), .AW(6)) u_sm_n (
        .clk(clk), .rst(rst), .s_addr(n_saddr), .s_be(n_sbe), .s_rd(n_srd), .s_wr(n_swr),
        .s_wdata(n_swdata), .s_rdata(n_srdata), .s_wait(n_swait), .wait_cyc(wc_n));

    bwa_adapter #(.SLV_W(8), .NATIVE(1'b0), .ADDR_W(8)) u_b8 (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_be(m_be), .m_rd(b_rd), .m_wr(b_wr),
        .m_wdata(m_wdata), .m_rdata(b_rdata), .m_wait(b_wait), .s_addr(b_saddr),
        .s_be(b_sbe), .s_rd(b_srd), .s_wr(b_swr), .s_wdata(b_swdata),
        .s_rdata(b_srdata), .s_wait(b_swait));
    bwa_slave_model #(.W(8), .AW(8)) u_sm_b (
        .clk(clk), .rst(rst), .s_addr(b_saddr), .s_be(b_sbe), .s_rd(b_srd), .s_wr(b_swr),
        .s_wdata(b_swdata), .s_rdata(b_srdata), .s_wait(b_swait), .wait_cyc(wc_b));

    // row: op(1=wr) | addr | be | wdata | exp rdata | slave cycles | first addr | last addr
    localparam int NV = 12;
    localparam logic [95:0] VEC [NV] = '{
        {1'b1, 8'h10, 4'hF, 32'h44332211, 32'h00000000, 3'd2, 8'h08, 8'h09}, // R2 R4 full write
        {1'b0, 8'h10, 4'hF, 32'h00000000, 32'h44332211, 3'd2, 8'h08, 8'h09}, // R2 R5 full read
        {1'b1, 8'h14, 4'h3, 32'hDDCCBBAA, 32'h00000000, 3'd1, 8'h0A, 8'h0A}, // R3 low half only
        {1'b0, 8'h14, 4'hF, 32'h00000000, 32'h0000BBAA, 3'd2, 8'h0A, 8'h0B}, // R4 R5
        {1'b1, 8'h18, 4'h8, 32'h99887766, 32'h00000000, 3'd1, 8'h0D, 8'h0D}, // R3 R4 lane 3 only
        {1'b0, 8'h18, 4'hC, 32'h00000000, 32'h99000000, 3'd1, 8'h0D, 8'h0D}, // R5 upper half
        {1'b1, 8'h10, 4'h5, 32'hEEEEFFFF, 32'h00000000, 3'd2, 8'h08, 8'h09}, // R4 sparse lanes
        {1'b0, 8'h10, 4'hF, 32'h00000000, 32'h44EE22FF, 3'd2, 8'h08, 8'h09}, // R4 R5 merge
        {1'b0, 8'h14, 4'h0, 32'h00000000, 32'h00000000, 3'd0, 8'h00, 8'h00}, // R7 empty read
        {1'b1, 8'h1C, 4'h0, 32'hFFFFFFFF, 32'h00000000, 3'd0, 8'h00, 8'h00}, // R7 empty write
        {1'b0, 8'h1C, 4'hF, 32'h00000000, 32'h00000000, 3'd2, 8'h0E, 8'h0F}, // R7 write had no effect
        {1'b0, 8'h14, 4'h2, 32'h00000000, 32'h0000BBAA, 3'd1, 8'h0A, 8'h0A}  // R3 R5 lane 1 only
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int acc_of(int sel);
        case (sel)
            0: return u_sm_d.acc_cnt;
            1: return u_sm_n.acc_cnt;
            default: return u_sm_b.acc_cnt;
        endcase
    endfunction

    function automatic int log_of(int sel, int k);
        case (sel)
            0: return int'(u_sm_d.log_a[4'(k)]);
            1: return int'(u_sm_n.log_a[4'(k)]);
            default: return int'(u_sm_b.log_a[4'(k)]);
        endcase
    endfunction

    function automatic logic wait_of(int sel);
        case (sel)
            0: return d_wait;
            1: return n_wait;
            default: return b_wait;
        endcase
    endfunction

    function automatic logic [31:0] rdata_of(int sel);
        case (sel)
            0: return d_rdata;
            1: return n_rdata;
            default: return b_rdata;
        endcase
    endfunction

    task automatic strobe(input int sel, input logic w, input logic on);
        case (sel)
            0: begin d_rd = on & ~w; d_wr = on & w; end
            1: begin n_rd = on & ~w; n_wr = on & w; end
            default: begin b_rd = on & ~w; b_wr = on & w; end
        endcase
    endtask

    task automatic xfer(input int sel, input logic w, input logic [7:0] a,
                        input logic [3:0] be, input logic [31:0] wd,
                        output logic [31:0] rdat, output int edges, output int nacc,
                        output int first_a, output int last_a);
        int c0;
        @(negedge clk);
        c0 = acc_of(sel);
        m_addr = a; m_be = be; m_wdata = wd;
        strobe(sel, w, 1'b1);
        edges = 0;
        do begin
            @(negedge clk);
            edges++;
        end while (wait_of(sel) && edges < 200);
        rdat = rdata_of(sel);
        strobe(sel, w, 1'b0);
        nacc    = acc_of(sel) - c0;
        first_a = log_of(sel, c0);
        last_a  = log_of(sel, c0 + nacc - 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int ed, na, fa, la;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        chk("R1 strobes", {30'd0, d_srd | n_srd | b_srd, d_swr | n_swr | b_swr}, 32'd0);
        chk("R1 wait", {29'd0, d_wait, n_wait, b_wait}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            xfer(0, VEC[i][95], VEC[i][94:87], VEC[i][86:83], VEC[i][82:51], rd, ed, na, fa, la);
            if (!VEC[i][95]) chk($sformatf("R5 row %0d rdata", i), rd, VEC[i][50:19]);
            chk($sformatf("R3 row %0d slave cycles", i), 32'(na), 32'(VEC[i][18:16]));
            if (VEC[i][18:16] != 3'd0) begin
                chk($sformatf("R2 row %0d first addr", i), 32'(fa), 32'(VEC[i][15:8]));
                chk($sformatf("R2 row %0d last addr", i), 32'(la), 32'(VEC[i][7:0]));
            end
            chk($sformatf("R6 row %0d latency", i), 32'(ed), 32'(VEC[i][18:16]) + 32'd1);
        end

        // R6: slave stalls two cycles per access
        wc_d = 2;
        xfer(0, 1'b0, 8'h10, 4'hF, 32'h0, rd, ed, na, fa, la);
        chk("R6 stalled rdata", rd, 32'h44EE22FF);
        chk("R6 stalled latency", 32'(ed), 32'd7);
        wc_d = 0;

        // R8: sparse mapping
        xfer(1, 1'b1, 8'h08, 4'hF, 32'hCAFEBABE, rd, ed, na, fa, la);
        chk("R8 one cycle", 32'(na), 32'd1);
        chk("R8 word addr", 32'(fa), 32'd2);
        chk("R8 stored low lanes", {16'd0, u_sm_n.mem[2]}, 32'h0000BABE);
        xfer(1, 1'b0, 8'h08, 4'hF, 32'h0, rd, ed, na, fa, la);
        chk("R8 upper lanes zero", rd, 32'h0000BABE);
        xfer(1, 1'b1, 8'h0C, 4'hC, 32'h12345678, rd, ed, na, fa, la);
        chk("R8 upper-only write no cycle", 32'(na), 32'd0);
        chk("R8 upper-only latency", 32'(ed), 32'd1);
        xfer(1, 1'b0, 8'h0C, 4'hF, 32'h0, rd, ed, na, fa, la);
        chk("R8 word 3 untouched", rd, 32'h00000000);

        // R9: byte-wide slave
        xfer(2, 1'b1, 8'h20, 4'hF, 32'h87654321, rd, ed, na, fa, la);
        chk("R9 four cycles", 32'(na), 32'd4);
        chk("R9 first addr", 32'(fa), 32'h20);
        chk("R9 last addr", 32'(la), 32'h23);
        chk("R9 latency", 32'(ed), 32'd5);
        xfer(2, 1'b0, 8'h20, 4'h6, 32'h0, rd, ed, na, fa, la);
        chk("R9 middle lanes", rd, 32'h00654300);
        chk("R9 two cycles", 32'(na), 32'd2);
        chk("R9 addr order", 32'(fa * 256 + la), 32'h2122);

        finish_run();
    end
endmodule